// File: doc/BRIEF.md
# Pilot-Tone Timing Recovery Loop

This block keeps a receiver's sample timing aligned with a far-end transmitter whose sample clock runs at a slightly different rate. Once per symbol it is given a signed phase-error reading taken on the pilot tone. A proportional-plus-integral loop filter turns that reading into a per-symbol phase step. The integral branch on its own is the running estimate of the frequency offset between the two clocks. The step is added into a phase accumulator, which holds the total timing drift in fractions of one sample period.

The correction works in two tiers. While the accumulated drift stays inside half a sample, it is reported as a rotation angle for a given tone, in a 16-bit turn format that a frequency-domain rotor can use directly. When the drift would leave that window, the block instead issues a one-cycle request to drop or repeat one sample of the incoming stream. In the same cycle it moves the accumulator by one whole sample, so the rotor angle continues from the rebased value. The rotor arithmetic and the stream slip logic sit outside this block; only their control values are produced here.

Top module: `pilot_dpll`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) or a synchronous clear (clear_i high at an edge), freq_est_o, phase_acc_o, rot_angle_o, slip_ins_o and slip_del_o are all zero. Clear takes priority over a strobe in the same cycle.
- R2: At an edge with sym_strobe_i high, the integrator becomes integ + (sign-extended phase_err_i >>> ki_shift_i), an arithmetic shift, saturated to ±2^21. freq_est_o shows the integrator after that edge.
- R3: The per-symbol phase step is the new integrator value plus (phase_err_i >>> kp_shift_i), saturated to ±2^21. It is added to the accumulator, where one sample period equals 2^22.
- R4: Without a strobe or a clear, the integrator, the accumulator, the rotor angle and both slip outputs hold; the slip outputs are then zero.
- R5: If accumulator + step exceeds +2^21, slip_del_o is high for the one cycle after the strobe edge and the accumulator takes accumulator + step − 2^22.
- R6: If accumulator + step is below −2^21, slip_ins_o is high for the one cycle after the strobe edge and the accumulator takes accumulator + step + 2^22.
- R7: slip_ins_o and slip_del_o are never high together, at most one slip follows each strobe, and each slip pulse lasts one cycle unless the next cycle also carries a strobe.
- R8: At each strobe edge, rot_angle_o becomes bits [30:15] of the signed product (new accumulator × tone_idx_i), with tone_idx_i taken as unsigned. This is a phase in which 2^16 is one full turn, for a 512-point transform.
- R9: The accumulator always stays within ±2^21, which is half a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the loop state |
| sym_strobe_i | input | 1 | One symbol's phase-error reading is valid |
| phase_err_i | input | 16 | Signed pilot-tone phase error |
| kp_shift_i | input | 5 | Right shift that sets the proportional gain |
| ki_shift_i | input | 5 | Right shift that sets the integral gain |
| tone_idx_i | input | 8 | Tone index used to scale the rotor angle |
| freq_est_o | output | 24 | Signed integrator value (frequency-offset estimate) |
| phase_acc_o | output | 24 | Signed accumulated phase, 2^22 per sample |
| rot_angle_o | output | 16 | Signed rotor angle, 2^16 per turn |
| slip_ins_o | output | 1 | Request to insert one sample |
| slip_del_o | output | 1 | Request to delete one sample |

## Verification
Every result of a strobe is registered at the same edge that samples the strobe. The integrator, accumulator, rotor angle and slip pulse can therefore all be read one edge after the inputs are driven. The bench drives inputs on the falling edge and compares all five outputs with its model on the next falling edge. After a strobe it inserts idle cycles and checks that the slip pulse has dropped and that the loop state has held. A clear is checked at the same one-edge latency, including a clear that arrives together with a strobe.

// File: rtl/pilot_dpll_pkg.sv
// Shared definitions for the pilot-tone timing loop.
// Assumes: nothing beyond IEEE 1800-2017.
package pilot_dpll_pkg;

    // Kind of sample slip decided for one symbol.
    typedef enum logic [1:0] {
        SLIP_NONE   = 2'd0,
        SLIP_INSERT = 2'd1,
        SLIP_DELETE = 2'd2
    } slip_kind_e;

endpackage

// File: rtl/pdpll_loop_filter.sv
// Proportional-plus-integral loop filter.
// Holds the integrator, which is the frequency-offset estimate, and gives
// out the saturated phase step for the current symbol combinationally.
// Assumes: ACC_W > ERR_W, and half a sample is 2^(ACC_W-3).
module pdpll_loop_filter #(
    parameter int ERR_W   = 16,
    parameter int ACC_W   = 24,
    parameter int SHIFT_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      strobe_i,
    input  logic signed [ERR_W-1:0]   err_i,
    input  logic [SHIFT_W-1:0]        kp_shift_i,
    input  logic [SHIFT_W-1:0]        ki_shift_i,
    output logic signed [ACC_W-1:0]   integ_o,
    output logic signed [ACC_W-1:0]   step_o
);
    localparam int HALF_EXP = ACC_W - 3;
    localparam logic signed [ACC_W:0]   LIM_W = (ACC_W+1)'(longint'(1) << HALF_EXP);
    localparam logic signed [ACC_W-1:0] LIM   = ACC_W'(longint'(1) << HALF_EXP);

    logic signed [ACC_W-1:0] err_ext;
    logic signed [ACC_W-1:0] i_term;
    logic signed [ACC_W-1:0] p_term;
    logic signed [ACC_W:0]   sum_i;
    logic signed [ACC_W:0]   sum_p;
    logic signed [ACC_W-1:0] integ_q;
    logic signed [ACC_W-1:0] integ_nx;

    assign err_ext = {{(ACC_W-ERR_W){err_i[ERR_W-1]}}, err_i};
    assign i_term  = err_ext >>> ki_shift_i;
    assign p_term  = err_ext >>> kp_shift_i;

    // Integrator update with saturation at half a sample.
    always_comb begin
        sum_i = {integ_q[ACC_W-1], integ_q} + {i_term[ACC_W-1], i_term};
        if (sum_i > LIM_W) begin
            integ_nx = LIM;
        end else if (sum_i < -LIM_W) begin
            integ_nx = -LIM;
        end else begin
            integ_nx = sum_i[ACC_W-1:0];
        end
    end

    // Phase step: new integrator plus proportional term, saturated.
    always_comb begin
        sum_p = {integ_nx[ACC_W-1], integ_nx} + {p_term[ACC_W-1], p_term};
        if (sum_p > LIM_W) begin
            step_o = LIM;
        end else if (sum_p < -LIM_W) begin
            step_o = -LIM;
        end else begin
            step_o = sum_p[ACC_W-1:0];
        end
    end

    // Integrator register, updated once per symbol strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            integ_q <= '0;
        end else if (strobe_i) begin
            integ_q <= integ_nx;
        end
    end

    assign integ_o = integ_q;

    assert_integ_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_q <= LIM) && (integ_q >= -LIM));

    assert_integ_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(strobe_i) && !$past(clear_i) && $past(rst_n)) |-> $stable(integ_q));

    assert_integ_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (integ_q == '0));
endmodule

// File: rtl/pdpll_phase_acc.sv
// Phase accumulator with the two-tier correction decision.
// Adds the per-symbol step. When the sum leaves +-half a sample, it
// issues a one-cycle slip request and moves the accumulator by one sample.
// Assumes: |step_i| <= half a sample (the loop filter guarantees it).
module pdpll_phase_acc
    import pilot_dpll_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     strobe_i,
    input  logic signed [ACC_W-1:0]  step_i,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic signed [ACC_W-1:0]  acc_nx_o,
    output logic                     ins_o,
    output logic                     del_o
);
    localparam int UNIT_EXP = ACC_W - 2;
    localparam logic signed [ACC_W:0]   FULL_W = (ACC_W+1)'(longint'(1) << UNIT_EXP);
    localparam logic signed [ACC_W:0]   HALF_W = (ACC_W+1)'(longint'(1) << (UNIT_EXP-1));
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(longint'(1) << (UNIT_EXP-1));

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   raw;
    logic signed [ACC_W:0]   fin;
    slip_kind_e              kind;

    // Decide the slip kind and the rebased accumulator value.
    always_comb begin
        raw = {acc_q[ACC_W-1], acc_q} + {step_i[ACC_W-1], step_i};
        if (raw > HALF_W) begin
            kind = SLIP_DELETE;
            fin  = raw - FULL_W;
        end else if (raw < -HALF_W) begin
            kind = SLIP_INSERT;
            fin  = raw + FULL_W;
        end else begin
            kind = SLIP_NONE;
            fin  = raw;
        end
    end

    assign acc_nx_o = fin[ACC_W-1:0];

    // Accumulator register, updated once per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            acc_q <= '0;
        end else if (strobe_i) begin
            acc_q <= acc_nx_o;
        end
    end

    // Slip request pulses, one per strobe at most.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ins_o <= 1'b0;
            del_o <= 1'b0;
        end else begin
            ins_o <= strobe_i && (kind == SLIP_INSERT);
            del_o <= strobe_i && (kind == SLIP_DELETE);
        end
    end

    assign acc_o = acc_q;

    assert_acc_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q <= HALF) && (acc_q >= -HALF));

    assert_slip_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_o && del_o));

    assert_slip_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_o || del_o) |-> ($past(strobe_i) && !$past(clear_i)));

    assert_del_rebase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        del_o |-> (acc_q <= 0));

    assert_ins_rebase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_o |-> (acc_q >= 0));

    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(strobe_i) && !$past(clear_i) && $past(rst_n)) |-> $stable(acc_q));

    assert_acc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (acc_q == '0 && !ins_o && !del_o));
endmodule

// File: rtl/pdpll_rotor_angle.sv
// Rotor angle register.
// Scales the accumulated phase (2^(ACC_W-2) per sample) by the tone index
// and returns the phase in turns, 2^ANG_W per turn, for a 2^LOG2_NFFT
// point transform. The result wraps modulo one turn.
// Assumes: ACC_W-2 + LOG2_NFFT >= ANG_W.
module pdpll_rotor_angle #(
    parameter int ACC_W     = 24,
    parameter int TONE_W    = 8,
    parameter int LOG2_NFFT = 9,
    parameter int ANG_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     strobe_i,
    input  logic signed [ACC_W-1:0]  acc_i,
    input  logic [TONE_W-1:0]        tone_i,
    output logic signed [ANG_W-1:0]  angle_o
);
    localparam int ROT_SHIFT = ACC_W - 2 + LOG2_NFFT - ANG_W;
    localparam int PROD_W    = ACC_W + TONE_W + 1;

    logic signed [PROD_W-1:0] acc_ext;
    logic signed [PROD_W-1:0] tone_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [ANG_W-1:0]  angle_nx;

    assign acc_ext  = {{(TONE_W+1){acc_i[ACC_W-1]}}, acc_i};
    assign tone_ext = {{(ACC_W+1){1'b0}}, tone_i};

    // Scale by tone index and keep one turn of phase.
    always_comb begin
        prod     = acc_ext * tone_ext;
        angle_nx = ANG_W'(prod >>> ROT_SHIFT);
    end

    // Angle register, refreshed at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            angle_o <= '0;
        end else if (strobe_i) begin
            angle_o <= angle_nx;
        end
    end

    assert_angle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(strobe_i) && !$past(clear_i) && $past(rst_n)) |-> $stable(angle_o));

    assert_angle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (angle_o == '0));
endmodule

// File: rtl/pilot_dpll.sv
// Pilot-tone timing recovery loop, top level.
// Chains the loop filter, the phase accumulator with slip decision, and
// the rotor angle register. Every result of a strobe appears one edge later.
// Assumes: at most one phase-error reading per cycle, flagged by the strobe.
module pilot_dpll #(
    parameter int ERR_W     = 16,
    parameter int ACC_W     = 24,
    parameter int SHIFT_W   = 5,
    parameter int TONE_W    = 8,
    parameter int LOG2_NFFT = 9,
    parameter int ANG_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     sym_strobe_i,
    input  logic signed [ERR_W-1:0]  phase_err_i,
    input  logic [SHIFT_W-1:0]       kp_shift_i,
    input  logic [SHIFT_W-1:0]       ki_shift_i,
    input  logic [TONE_W-1:0]        tone_idx_i,
    output logic signed [ACC_W-1:0]  freq_est_o,
    output logic signed [ACC_W-1:0]  phase_acc_o,
    output logic signed [ANG_W-1:0]  rot_angle_o,
    output logic                     slip_ins_o,
    output logic                     slip_del_o
);
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] acc_nx;

    pdpll_loop_filter #(
        .ERR_W   (ERR_W),
        .ACC_W   (ACC_W),
        .SHIFT_W (SHIFT_W)
    ) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .strobe_i   (sym_strobe_i),
        .err_i      (phase_err_i),
        .kp_shift_i (kp_shift_i),
        .ki_shift_i (ki_shift_i),
        .integ_o    (freq_est_o),
        .step_o     (step)
    );

    pdpll_phase_acc #(
        .ACC_W (ACC_W)
    ) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .strobe_i (sym_strobe_i),
        .step_i   (step),
        .acc_o    (phase_acc_o),
        .acc_nx_o (acc_nx),
        .ins_o    (slip_ins_o),
        .del_o    (slip_del_o)
    );

    pdpll_rotor_angle #(
        .ACC_W     (ACC_W),
        .TONE_W    (TONE_W),
        .LOG2_NFFT (LOG2_NFFT),
        .ANG_W     (ANG_W)
    ) rot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_i),
        .strobe_i (sym_strobe_i),
        .acc_i    (acc_nx),
        .tone_i   (tone_idx_i),
        .angle_o  (rot_angle_o)
    );

    assert_slip_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_ins_o || slip_del_o) |-> $onehot0({slip_ins_o, slip_del_o}));
endmodule

// File: tb/pilot_dpll_tb_top.sv
// Bench for the pilot-tone timing loop: model-based checks on every strobe.
module pilot_dpll_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam longint FULL = 64'sd4194304;
    localparam longint HALF = 64'sd2097152;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0;
    logic sym_strobe_i = 1'b0;
    logic signed [15:0] phase_err_i = '0;
    logic [4:0] kp_shift_i = '0;
    logic [4:0] ki_shift_i = '0;
    logic [7:0] tone_idx_i = '0;
    logic signed [23:0] freq_est_o;
    logic signed [23:0] phase_acc_o;
    logic signed [15:0] rot_angle_o;
    logic slip_ins_o;
    logic slip_del_o;

    int n_checks = 0;
    int n_fail = 0;
    int n_del = 0;
    int n_ins = 0;
    int cyc = 0;
    longint m_integ = 0, m_acc = 0, m_rot = 0;
    int m_ins = 0, m_del = 0;

    pilot_dpll dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sym_strobe_i(sym_strobe_i),
        .phase_err_i(phase_err_i), .kp_shift_i(kp_shift_i), .ki_shift_i(ki_shift_i),
        .tone_idx_i(tone_idx_i), .freq_est_o(freq_est_o), .phase_acc_o(phase_acc_o),
        .rot_angle_o(rot_angle_o), .slip_ins_o(slip_ins_o), .slip_del_o(slip_del_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic longint sat(longint v);
        if (v > HALF) return HALF;
        if (v < -HALF) return -HALF;
        return v;
    endfunction

    function automatic longint rot_of(longint acc, int tone);
        return ((acc * longint'(tone)) >>> 15) & 64'hFFFF;
    endfunction

    // Reference model for one strobe, straight from R2, R3, R5, R6, R8.
    task automatic model_strobe(longint err, int kp, int ki, int tone);
        longint raw;
        m_integ = sat(m_integ + (err >>> ki));
        raw = m_acc + sat(m_integ + (err >>> kp));
        m_ins = 0; m_del = 0;
        if (raw > HALF) begin
            m_del = 1; raw = raw - FULL;
        end else if (raw < -HALF) begin
            m_ins = 1; raw = raw + FULL;
        end
        m_acc = raw;
        m_rot = rot_of(m_acc, tone);
    endtask

    task automatic model_zero();
        m_integ = 0; m_acc = 0; m_rot = 0; m_ins = 0; m_del = 0;
    endtask

    task automatic check(string req, string what, longint act, longint exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "freq_est", longint'(freq_est_o), m_integ);
        check(req, "phase_acc", longint'(phase_acc_o), m_acc);
        check(req, "rot_angle", longint'({48'd0, rot_angle_o}), m_rot);
        check(req, "slip_ins", longint'(slip_ins_o), longint'(m_ins));
        check(req, "slip_del", longint'(slip_del_o), longint'(m_del));
        check("R7", "slip_excl", longint'(slip_ins_o & slip_del_o), 0);
        if (slip_del_o) n_del = n_del + 1;
        if (slip_ins_o) n_ins = n_ins + 1;
    endtask

    // Drive one strobe at a falling edge, check at the next falling edge.
    task automatic strobe(int err, int kp, int ki, int tone, string req);
        phase_err_i = 16'(err);
        kp_shift_i = 5'(kp);
        ki_shift_i = 5'(ki);
        tone_idx_i = 8'(tone);
        sym_strobe_i = 1'b1;
        @(negedge clk);
        sym_strobe_i = 1'b0;
        model_strobe(longint'(phase_err_i), kp, ki, tone);
        check_all(req);
    endtask

    // Idle cycle with noisy inputs: state holds, slips drop (R4).
    task automatic idle(string req);
        phase_err_i = 16'($urandom);
        tone_idx_i = 8'($urandom);
        @(negedge clk);
        m_ins = 0; m_del = 0;
        check_all(req);
    endtask

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd24681);
        repeat (4) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Directed: proportional step only, then an idle hold (R3, R4).
        strobe(1000, 0, 31, 100, "R3");
        idle("R4");
        // Negative error, integral branch (R2, R8).
        strobe(-5000, 2, 1, 255, "R2");
        strobe(-5000, 2, 1, 255, "R8");
        idle("R4");

        // Drive to saturation and deletes (R2, R5, R9).
        for (int i = 0; i < 120; i++) strobe(32767, 0, 0, 37, "R5");
        check("R2", "integ_saturated", longint'(freq_est_o), HALF);
        idle("R7");
        // Clear together with a strobe: clear wins (R1).
        clear_i = 1'b1;
        sym_strobe_i = 1'b1;
        phase_err_i = 16'sd20000;
        @(negedge clk);
        clear_i = 1'b0;
        sym_strobe_i = 1'b0;
        model_zero();
        check_all("R1");
        // Drive the other way for inserts (R6).
        for (int i = 0; i < 120; i++) strobe(-32768, 0, 0, 200, "R6");
        check("R2", "integ_neg_sat", longint'(freq_est_o), -HALF);
        idle("R4");

        // Random mix with bias phases, occasional idles and clears.
        for (int i = 0; i < 2500; i++) begin
            int bias;
            int e;
            bias = ((i / 300) % 2 == 0) ? 6000 : -6000;
            e = int'($urandom_range(0, 40000)) - 20000 + bias;
            strobe(e, int'($urandom_range(0, 6)), int'($urandom_range(3, 10)),
                   int'($urandom_range(0, 255)), "R9");
            if ($urandom_range(0, 9) == 0) idle("R4");
            if ($urandom_range(0, 499) == 0) begin
                clear_i = 1'b1;
                @(negedge clk);
                clear_i = 1'b0;
                model_zero();
                check_all("R1");
            end
        end
        check("R5", "deletes_seen", longint'(n_del > 0), 1);
        check("R6", "inserts_seen", longint'(n_ins > 0), 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule